// File: doc/BRIEF.md
# Four-Way Read Cache Controller with Way Lockdown

This block sits between a 32-bit core's word-read port and a slower line-refill port. It keeps a tag, a valid bit and eight data words for each line in four ways. A read that hits returns its word in the same cycle. A read that misses fetches the whole eight-word line through the refill port, and the word goes back to the core once the last beat has arrived. The core waits by holding its request while the ready output stays low.

The line is allocated only when the core marks the read as cacheable and at least one way is unlocked. The replaced way is chosen as follows. An unlocked way that is empty in the addressed set is taken first, lowest number first. Otherwise a round-robin pointer picks a way and skips every locked way. Software can lock any subset of the ways. A locked way still serves hits but is never replaced. A single invalidate-all command clears every valid bit, and it acts only when its operand is zero. The total cache size is a parameter, and the set count and index width follow from it.

Top module: `rdcache_top`

## Requirements
- R1: When `req_valid` is high and the addressed line is present, `rsp_ready` is high in the same cycle with the addressed word on `rsp_data`, and no refill is started.
- R2: A cacheable read miss raises `fill_req` in the next cycle with `fill_addr` set to the line address (bits [4:0] zero). After eight beats are taken on `fill_data_valid`, with beat k carrying the word at line offset 4*k, `rsp_ready` is high in the following cycle with the requested word. A later read of the same line hits.
- R3: A read with `req_cacheable` low is served through the refill port exactly as a miss, but it allocates nothing, so repeating it misses again.
- R4: A pulse on `inv_valid` with `inv_operand` equal to zero clears every valid bit, and the next read of any previously cached line misses. A pulse with a nonzero operand is ignored.
- R5: On allocation, an invalid way whose `lock_mask` bit is clear is preferred over valid ways, with the lowest way number winning.
- R6: When every unlocked way of the set is valid, the victim is the first unlocked way at or after a 2-bit round-robin pointer (wrapping 3 to 0). After the replacement the pointer moves to the victim plus one. The pointer is zero after reset and does not move when an invalid way is filled.
- R7: A way whose `lock_mask` bit (bit n for way n) is set is never chosen as victim but still returns hits.
- R8: With all four `lock_mask` bits set, a miss is still served through the refill port but allocates nothing.
- R9: Address bits [4:2] select the word within the line and bits [1:0] are ignored.
- R10: The set index is address bits [IDX_W+4:5] with IDX_W = log2(CACHE_BYTES/128). Four lines whose addresses differ only in tag bits coexist in one set, and a fifth evicts one of them.
- R11: While `fill_req` is high, `fill_addr` is stable and `rsp_ready` is low. `fill_req` drops after exactly eight accepted beats.
- R12: After reset `rsp_ready` and `fill_req` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core read request, held until `rsp_ready` |
| req_addr | input | 32 | Byte address of the read |
| req_cacheable | input | 1 | Read may allocate a line |
| rsp_ready | output | 1 | Read data valid this cycle |
| rsp_data | output | 32 | Read data word |
| inv_valid | input | 1 | Invalidate-all command pulse |
| inv_operand | input | 32 | Command operand; must be zero to act |
| lock_mask | input | 4 | Per-way lock, bit n locks way n |
| fill_req | output | 1 | Line refill request, held until the eighth beat |
| fill_addr | output | 32 | Line-aligned refill address |
| fill_data_valid | input | 1 | Refill beat present |
| fill_data | input | 32 | Refill beat word |

## Verification
Reads run against cold sets, warm sets, sets with all four ways full, and sets with some or all ways locked. Comparing refill counts before and after each read separates hits from misses. Comparing the returned word with a value derived from its address checks the word select and the beat order. Five lines sent to one set, followed by probes of which lines still hit, show which way was replaced, and so separate invalid-way preference, pointer advance and lock skipping. Uncacheable reads, all-locked reads and both invalidate operands each use a repeated read to show whether allocation happened.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    localparam int unsigned WAYS       = 4;
    localparam int unsigned WAY_W      = 2;
    localparam int unsigned LINE_WORDS = 8;
    localparam int unsigned WSEL_W     = 3;
    localparam int unsigned OFF_W      = 5;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LNUM_W     = ADDR_W - OFF_W;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RESP} rdc_state_e;

    typedef logic [LINE_WORDS-1:0][DATA_W-1:0] line_t;

    typedef struct packed {
        logic [LNUM_W-1:0] line_no;
        logic [WSEL_W-1:0] word;
        logic              alloc;
        logic              fresh;
        logic [WAY_W-1:0]  way;
    } miss_rec_t;

    function automatic logic [WAY_W-1:0] way_enc(input logic [WAYS-1:0] vec);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = 0; i < WAYS; i++)
            if (vec[i]) r = WAY_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/rdc_tag_store.sv
module rdc_tag_store
    import rdc_pkg::*;
#(
    parameter int unsigned SETS  = 32,
    parameter int unsigned IDX_W = 5,
    parameter int unsigned TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [WAYS-1:0]  valid_vec,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inv_all
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  vbits;
        logic             sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst)          vbits <= '0;
            else if (inv_all) vbits <= '0;
            else if (sel)     vbits[wr_idx] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (sel) tags[wr_idx] <= wr_tag;
        end

        assign valid_vec[w] = vbits[lk_idx];
        assign hit_vec[w]   = vbits[lk_idx] && (tags[lk_idx] == lk_tag);
    end
endmodule

// File: rtl/rdc_data_store.sv
module rdc_data_store
    import rdc_pkg::*;
#(
    parameter int unsigned SETS  = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_t             wr_line,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = SETS * LINE_WORDS;

    logic [DATA_W-1:0] way_out [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] words [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(w))) begin
                for (int i = 0; i < LINE_WORDS; i++)
                    words[{wr_idx, WSEL_W'(i)}] <= wr_line[i];
            end
        end

        assign way_out[w] = words[{rd_idx, rd_word}];
    end

    assign rd_data = way_out[rd_way];
endmodule

// File: rtl/rdc_victim_sel.sv
module rdc_victim_sel
    import rdc_pkg::*;
(
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAYS-1:0]  lock_mask,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             can_alloc,
    output logic             use_invalid
);
    logic [WAY_W-1:0] probe;

    always_comb begin
        can_alloc   = 1'b0;
        use_invalid = 1'b0;
        victim      = '0;
        probe       = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (!can_alloc && !valid_vec[i] && !lock_mask[i]) begin
                can_alloc   = 1'b1;
                use_invalid = 1'b1;
                victim      = WAY_W'(i);
            end
        end
        for (int k = 0; k < WAYS; k++) begin
            probe = rr_ptr + WAY_W'(k);
            if (!can_alloc && !lock_mask[probe]) begin
                can_alloc = 1'b1;
                victim    = probe;
            end
        end
    end
endmodule

// File: rtl/rdcache_top.sv
module rdcache_top
    import rdc_pkg::*;
#(
    parameter int unsigned CACHE_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_cacheable,
    output logic        rsp_ready,
    output logic [31:0] rsp_data,
    input  logic        inv_valid,
    input  logic [31:0] inv_operand,
    input  logic [3:0]  lock_mask,
    output logic        fill_req,
    output logic [31:0] fill_addr,
    input  logic        fill_data_valid,
    input  logic [31:0] fill_data
);
    localparam int unsigned LINE_BYTES = LINE_WORDS * 4;
    localparam int unsigned SETS       = CACHE_BYTES / (WAYS * LINE_BYTES);
    localparam int unsigned IDX_W      = $clog2(SETS);
    localparam int unsigned TAG_W      = LNUM_W - IDX_W;

    rdc_state_e        state;
    miss_rec_t         miss;
    line_t             line_buf;
    logic [WSEL_W-1:0] beat;
    logic [WAY_W-1:0]  rr_ptr;

    logic [LNUM_W-1:0] req_line;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_word;
    logic [WAYS-1:0]   hit_vec, valid_vec;
    logic              hit_any;
    logic [DATA_W-1:0] hit_data;
    logic [WAY_W-1:0]  victim;
    logic              can_alloc, use_invalid;
    logic              wr_en, inv_all;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign req_idx  = req_line[IDX_W-1:0];
    assign req_tag  = req_line[LNUM_W-1:IDX_W];
    assign req_word = req_addr[OFF_W-1:2];
    assign hit_any  = |hit_vec;
    assign wr_en    = (state == ST_RESP) && miss.alloc;
    assign inv_all  = inv_valid && (inv_operand == '0);

    rdc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (req_idx),
        .lk_tag    (req_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .wr_en     (wr_en),
        .wr_way    (miss.way),
        .wr_idx    (miss.line_no[IDX_W-1:0]),
        .wr_tag    (miss.line_no[LNUM_W-1:IDX_W]),
        .inv_all   (inv_all)
    );

    rdc_data_store #(.SETS(SETS), .IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_way  (miss.way),
        .wr_idx  (miss.line_no[IDX_W-1:0]),
        .wr_line (line_buf),
        .rd_way  (way_enc(hit_vec)),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (hit_data)
    );

    rdc_victim_sel u_victim (
        .valid_vec   (valid_vec),
        .lock_mask   (lock_mask),
        .rr_ptr      (rr_ptr),
        .victim      (victim),
        .can_alloc   (can_alloc),
        .use_invalid (use_invalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            miss   <= '0;
            beat   <= '0;
            rr_ptr <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid && !hit_any) begin
                        miss.line_no <= req_line;
                        miss.word    <= req_word;
                        miss.alloc   <= req_cacheable && can_alloc;
                        miss.fresh   <= use_invalid;
                        miss.way     <= victim;
                        beat         <= '0;
                        state        <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_data_valid) begin
                        beat <= beat + 1'b1;
                        if (beat == WSEL_W'(LINE_WORDS - 1)) state <= ST_RESP;
                    end
                end
                default: begin
                    if (miss.alloc && !miss.fresh) rr_ptr <= miss.way + 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_FILL && fill_data_valid) line_buf[beat] <= fill_data;
    end

    assign fill_req  = (state == ST_FILL);
    assign fill_addr = {miss.line_no, {OFF_W{1'b0}}};
    assign rsp_ready = (state == ST_RESP) || (state == ST_IDLE && req_valid && hit_any);
    assign rsp_data  = (state == ST_RESP) ? line_buf[miss.word] : hit_data;
endmodule

// File: rtl/rdcache_chk.sv
module rdcache_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        rsp_ready,
    input logic        fill_req,
    input logic [31:0] fill_addr,
    input logic        fill_data_valid
);
    logic [3:0] beats_seen;

    always_ff @(posedge clk) begin
        if (rst || !fill_req)     beats_seen <= '0;
        else if (fill_data_valid) beats_seen <= beats_seen + 1'b1;
    end

    // R1
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> req_valid);

    // R2
    fill_line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (fill_addr[4:0] == 5'd0));

    // R2
    rsp_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_req) |-> rsp_ready);

    // R11
    fill_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && $past(fill_req)) |-> $stable(fill_addr));

    // R11
    no_rsp_during_fill_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !rsp_ready);

    // R11
    fill_beat_limit_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (beats_seen < 4'd8));
endmodule

bind rdcache_top rdcache_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .rsp_ready       (rsp_ready),
    .fill_req        (fill_req),
    .fill_addr       (fill_addr),
    .fill_data_valid (fill_data_valid)
);

// File: tb/rdcache_top_tb.sv
`timescale 1ns/1ps
module rdcache_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_cacheable = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_data;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_operand = '0;
    logic [3:0]  lock_mask = '0;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_data_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int fails = 0;
    int fill_count = 0;
    int beat = 0;
    int gap_cnt = 0;
    bit gap_mode = 1'b0;
    bit prev_fill = 1'b0;
    bit finished = 1'b0;

    localparam logic [31:0] SET3 = 32'h0004_0060;
    localparam logic [31:0] STRIDE = 32'h0000_0400;

    always #2 clk = ~clk;

    rdcache_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_cacheable(req_cacheable), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .inv_valid(inv_valid), .inv_operand(inv_operand), .lock_mask(lock_mask),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_data_valid(fill_data_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] mval(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] aset(input int k);
        return SET3 + STRIDE * 32'(k);
    endfunction

    // refill responder: eight beats, optional idle gaps
    always @(negedge clk) begin
        if (fill_req && !prev_fill) fill_count++;
        prev_fill = fill_req;
        if (fill_req && beat < 8) begin
            gap_cnt++;
            if (gap_mode && (gap_cnt % 3 == 0)) begin
                fill_data_valid = 1'b0;
            end else begin
                fill_data_valid = 1'b1;
                fill_data = mval(fill_addr + 32'(beat * 4));
                beat++;
            end
        end else begin
            fill_data_valid = 1'b0;
            if (!fill_req) beat = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, input bit cach, input bit exp_miss, input string req);
        int n0;
        int cyc;
        logic [31:0] got;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_cacheable = cach;
        n0 = fill_count;
        cyc = 0;
        #1;
        while (!rsp_ready && cyc < 100) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        got = rsp_data;
        chk(rsp_ready, {req, " ready"}, 32'(rsp_ready), 32'd1);
        chk((fill_count != n0) == exp_miss, {req, " miss"}, 32'(fill_count - n0), 32'(exp_miss));
        chk(got == mval(a), {req, " data"}, got, mval(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic inv(input logic [31:0] op);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_operand = op;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_reset;
        // R12
        chk(!rsp_ready, "R12 ready", 32'(rsp_ready), 0);
        chk(!fill_req, "R12 fill_req", 32'(fill_req), 0);
    endtask

    task automatic t_basic;
        // R2 / R1 / R9 / R12
        rd(32'h0000_0100, 1, 1, "R2 cold miss");
        rd(32'h0000_0114, 1, 0, "R1 hit word5 R9");
        rd(32'h0000_0117, 1, 0, "R9 low bits ignored");
        rd(32'h0000_011C, 1, 0, "R9 last word");
    endtask

    task automatic t_uncached;
        rd(32'h0000_2008, 0, 1, "R3 uncached first");
        rd(32'h0000_2008, 0, 1, "R3 uncached repeat");
        rd(32'h0000_2008, 1, 1, "R3 cacheable fill");
        rd(32'h0000_200C, 1, 0, "R3 cacheable hit");
    endtask

    task automatic t_inval;
        inv(32'h0000_0005);
        rd(32'h0000_0104, 1, 0, "R4 nonzero operand ignored");
        inv(32'h0);
        rd(32'h0000_0104, 1, 1, "R4 zero operand clears");
        rd(32'h0000_2008, 1, 1, "R4 other line cleared");
    endtask

    task automatic t_replace;
        inv(32'h0);
        gap_mode = 1'b1;
        for (int k = 0; k < 4; k++) rd(aset(k), 1, 1, "R5 fill empty ways");
        gap_mode = 1'b0;
        for (int k = 0; k < 4; k++) rd(aset(k) + 32'h4, 1, 0, "R10 four lines share set");
        rd(aset(4), 1, 1, "R6 fifth line");
        rd(aset(5), 1, 1, "R6 sixth line");
        rd(aset(2), 1, 0, "R6 way2 kept");
        rd(aset(3), 1, 0, "R6 way3 kept");
        rd(aset(4), 1, 0, "R6 new line hits");
        rd(aset(5), 1, 0, "R6 new line hits");
        rd(aset(0), 1, 1, "R6 way0 evicted first");
    endtask

    task automatic t_lock;
        lock_mask = 4'b1000;
        for (int k = 6; k < 10; k++) rd(aset(k), 1, 1, "R7 misses with way3 locked");
        rd(aset(3), 1, 0, "R7 locked way still hits");
        rd(aset(7), 1, 0, "R7 way1 line");
        rd(aset(8), 1, 0, "R7 way2 line");
        rd(aset(9), 1, 0, "R7 way0 line");
        rd(aset(6), 1, 1, "R7 skipped line evicted");
    endtask

    task automatic t_all_locked;
        lock_mask = 4'b1111;
        rd(aset(10), 1, 1, "R8 served");
        rd(aset(10), 1, 1, "R8 not allocated");
        rd(aset(3), 1, 0, "R8 locked hit");
        rd(aset(9), 1, 0, "R8 locked hit");
        lock_mask = 4'b0000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_basic();
        t_uncached();
        t_inval();
        t_replace();
        t_lock();
        t_all_locked();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule